// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block sits between the core-side peripheral logic and the chip pads. Every pad contributes three scan cells: one on the pad input path toward the core, one on the core's data output toward the pad, and one on the core's output enable toward the pad. Each cell has a shift flop, a hold flop and a selection multiplexer. All cells are linked into one serial path from `tdi_i` to `tdo_o`.

A TAP controller outside the block supplies one-cycle capture, shift and update strobes on `tck_i`, together with a decoded instruction on `mode_i`. In functional mode, signals pass straight through the block. SAMPLE takes a snapshot of both the pad side and the core side without disturbing either. EXTEST lets the scanned-in and updated values drive the pad data, the pad direction and the value the core sees, in place of the live signals. The number of pads is a parameter, and the chain holds three cells per pad.

Top module: `bscan_chain`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every shift flop and hold flop is 0. `tdo_o` is 0 and all three output groups follow the functional path until the next update.
- R2: With the functional path selected, `pad_do_o` equals `core_do_i`, `pad_oe_o` equals `core_oe_i` and `core_di_o` equals `pad_di_i`, with no register delay.
- R3: An update strobe with `mode_i`=2 (EXTEST) copies the shift flops into the hold flops. From the next cycle on, pad p drives `core_di_o[p]` from cell 3p, `pad_do_o[p]` from cell 3p+1 and `pad_oe_o[p]` from cell 3p+2.
- R4: A capture strobe in SAMPLE (`mode_i`=1) or EXTEST loads cell 3p from `pad_di_i[p]`, cell 3p+1 from `core_do_i[p]` and cell 3p+2 from `core_oe_i[p]`.
- R5: A shift strobe in SAMPLE or EXTEST moves every cell one place toward the TDO end. `tdi_i` enters cell 0, and `tdo_o` shows the last cell (index 3*N_PADS-1). When capture and shift arrive in the same cycle, capture takes priority.
- R6: Hold flops change only on an update strobe. Shifting does not disturb the values driven in EXTEST.
- R7: An update in SAMPLE loads the hold flops but leaves all outputs on the functional path, so scanned-in data reaches no functional signal.
- R8: An update in any mode other than EXTEST, or a reset, returns all multiplexers to the functional path.
- R9: In functional mode (`mode_i`=0) or the reserved code 3, capture and shift strobes leave the chain contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 0 functional, 1 SAMPLE, 2 EXTEST, 3 reserved (functional) |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out (last cell) |
| pad_di_i | input | N_PADS | Values arriving from the pads |
| core_di_o | output | N_PADS | Pad input values delivered to the core |
| core_do_i | input | N_PADS | Core output data |
| core_oe_i | input | N_PADS | Core output enables |
| pad_do_o | output | N_PADS | Output data to the pads |
| pad_oe_o | output | N_PADS | Output enables to the pads |

## Verification
Each instruction is tried with an all-ones and an all-zeros scan vector while the live signals are set to the opposite value, so any leak from the wrong source shows. SAMPLE entries pair a loaded hold register with functional outputs, which separates "updated" from "selected". A pattern that sets only the enable cells, and mixed per-pad patterns, expose mistakes in the cell ordering and in the triplet mapping. Directed cases cover shifting while EXTEST is driving, strobes in functional mode, capture and shift arriving together, and reset out of EXTEST.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef enum logic [1:0] {
    BS_FUNC   = 2'd0,
    BS_SAMPLE = 2'd1,
    BS_EXTEST = 2'd2,
    BS_RSVD   = 2'd3
  } bs_mode_e;

  localparam int unsigned CELLS_PER_PAD = 3;
  localparam int unsigned OFS_IN  = 0;  // pad -> core
  localparam int unsigned OFS_OUT = 1;  // core -> pad data
  localparam int unsigned OFS_OE  = 2;  // core -> pad enable
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic cap_i,
  input  logic shf_i,
  input  logic upd_i,
  input  logic sel_i,
  input  logic ser_i,
  input  logic data_i,
  output logic ser_o,
  output logic hold_o,
  output logic data_o
);
  logic sh_q, hold_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= 1'b0;
    else if (cap_i) sh_q <= data_i;
    else if (shf_i) sh_q <= ser_i;
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= 1'b0;
    else if (upd_i) hold_q <= sh_q;
  end

  assign ser_o  = sh_q;
  assign hold_o = hold_q;
  assign data_o = sel_i ? hold_q : data_i;
endmodule

// File: rtl/bscan_ctl.sv
module bscan_ctl
  import bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  output logic       cap_o,
  output logic       shf_o,
  output logic       upd_o,
  output logic       sel_o
);
  bs_mode_e mode;
  logic     chain_on, sel_q;

  assign mode     = bs_mode_e'(mode_i);
  assign chain_on = (mode == BS_SAMPLE) || (mode == BS_EXTEST);
  assign cap_o    = chain_on & capture_i;
  assign shf_o    = chain_on & shift_i;
  assign upd_o    = chain_on & update_i;

  // selection follows the instruction present at the last update
  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= 1'b0;
    else if (update_i) sel_q <= (mode == BS_EXTEST);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int unsigned N_PADS = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              capture_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic [N_PADS-1:0] pad_di_i,
  output logic [N_PADS-1:0] core_di_o,
  input  logic [N_PADS-1:0] core_do_i,
  input  logic [N_PADS-1:0] core_oe_i,
  output logic [N_PADS-1:0] pad_do_o,
  output logic [N_PADS-1:0] pad_oe_o
);
  localparam int unsigned LEN = N_PADS * CELLS_PER_PAD;

  logic           cap_en, shf_en, upd_en, sel_q;
  logic [LEN-1:0] obs_w, drv_w, sr_q, hold_q;

  bscan_ctl u_ctl (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .mode_i   (mode_i),
    .capture_i(capture_i),
    .shift_i  (shift_i),
    .update_i (update_i),
    .cap_o    (cap_en),
    .shf_o    (shf_en),
    .upd_o    (upd_en),
    .sel_o    (sel_q)
  );

  for (genvar p = 0; p < N_PADS; p++) begin : g_pad
    assign obs_w[CELLS_PER_PAD*p+OFS_IN]  = pad_di_i[p];
    assign obs_w[CELLS_PER_PAD*p+OFS_OUT] = core_do_i[p];
    assign obs_w[CELLS_PER_PAD*p+OFS_OE]  = core_oe_i[p];
    assign core_di_o[p] = drv_w[CELLS_PER_PAD*p+OFS_IN];
    assign pad_do_o[p]  = drv_w[CELLS_PER_PAD*p+OFS_OUT];
    assign pad_oe_o[p]  = drv_w[CELLS_PER_PAD*p+OFS_OE];
  end

  for (genvar i = 0; i < LEN; i++) begin : g_cell
    logic ser_in;
    if (i == 0) begin : g_head
      assign ser_in = tdi_i;
    end else begin : g_link
      assign ser_in = sr_q[i-1];
    end

    bscan_cell u_cell (
      .tck_i (tck_i),
      .rst_ni(rst_ni),
      .cap_i (cap_en),
      .shf_i (shf_en),
      .upd_i (upd_en),
      .sel_i (sel_q),
      .ser_i (ser_in),
      .data_i(obs_w[i]),
      .ser_o (sr_q[i]),
      .hold_o(hold_q[i]),
      .data_o(drv_w[i])
    );
  end

  assign tdo_o = sr_q[LEN-1];
endmodule

// File: rtl/bscan_chain_chk.sv
module bscan_chain_chk #(
  parameter int unsigned N_PADS = 4,
  parameter int unsigned LEN    = 3 * N_PADS
) (
  input logic              tck_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic              capture_i,
  input logic              shift_i,
  input logic              update_i,
  input logic              tdo_o,
  input logic [LEN-1:0]    sr_q,
  input logic [LEN-1:0]    hold_q,
  input logic [N_PADS-1:0] pad_di_i,
  input logic [N_PADS-1:0] core_do_i,
  input logic [N_PADS-1:0] core_oe_i,
  input logic [N_PADS-1:0] core_di_o,
  input logic [N_PADS-1:0] pad_do_o,
  input logic [N_PADS-1:0] pad_oe_o
);
  logic on;
  assign on = (mode_i == 2'd1) || (mode_i == 2'd2);

  assert_extest_drive_R3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_i && mode_i == 2'd2) |=>
      (core_di_o[0] == $past(sr_q[0]) && pad_do_o[0] == $past(sr_q[1]) &&
       pad_oe_o[0] == $past(sr_q[2])));

  assert_capture_R4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (capture_i && on) |=>
      (sr_q[0] == $past(pad_di_i[0]) && sr_q[1] == $past(core_do_i[0]) &&
       sr_q[2] == $past(core_oe_i[0])));

  assert_shift_out_R5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (shift_i && !capture_i && on) |=> (tdo_o == $past(sr_q[LEN-2])));

  assert_hold_stable_R6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !update_i |=> $stable(hold_q));

  assert_release_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (update_i && mode_i != 2'd2) |=>
      (pad_do_o == core_do_i && pad_oe_o == core_oe_i && core_di_o == pad_di_i));

  assert_idle_chain_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !on |=> $stable(sr_q));
endmodule

bind bscan_chain bscan_chain_chk #(.N_PADS(N_PADS)) u_chk (
  .tck_i    (tck_i),
  .rst_ni   (rst_ni),
  .mode_i   (mode_i),
  .capture_i(capture_i),
  .shift_i  (shift_i),
  .update_i (update_i),
  .tdo_o    (tdo_o),
  .sr_q     (sr_q),
  .hold_q   (hold_q),
  .pad_di_i (pad_di_i),
  .core_do_i(core_do_i),
  .core_oe_i(core_oe_i),
  .core_di_o(core_di_o),
  .pad_do_o (pad_do_o),
  .pad_oe_o (pad_oe_o)
);

// File: tb/bscan_chain_test.sv
module bscan_chain_test;
  localparam int NP  = 4;
  localparam int LEN = 3 * NP;
  localparam logic [1:0] M_FUNC = 2'd0, M_SAMP = 2'd1, M_EXT = 2'd2;

  // {mode[25:24], scan pattern[23:12], pad_di[11:8], core_do[7:4], core_oe[3:0]}
  localparam logic [25:0] TBL [6] = '{
    {M_EXT,  12'hFFF, 4'h0, 4'h0, 4'h0},
    {M_SAMP, 12'hFFF, 4'h0, 4'h0, 4'h0},
    {M_EXT,  12'h000, 4'hF, 4'hF, 4'hF},
    {M_SAMP, 12'h000, 4'hF, 4'hF, 4'hF},
    {M_EXT,  12'hA5C, 4'h6, 4'h3, 4'h9},
    {M_EXT,  12'h924, 4'h1, 4'hE, 4'h0}
  };

  logic tck = 1'b0, rst_ni = 1'b0;
  logic [1:0] mode_i = M_FUNC;
  logic capture_i = 0, shift_i = 0, update_i = 0, tdi_i = 0, tdo_o;
  logic [NP-1:0] pad_di_i = '0, core_do_i = '0, core_oe_i = '0;
  logic [NP-1:0] core_di_o, pad_do_o, pad_oe_o;
  int n_chk = 0, n_bad = 0;

  always #2.5 tck = ~tck;

  bscan_chain #(.N_PADS(NP)) uut (
    .tck_i(tck), .rst_ni(rst_ni), .mode_i(mode_i),
    .capture_i(capture_i), .shift_i(shift_i), .update_i(update_i),
    .tdi_i(tdi_i), .tdo_o(tdo_o),
    .pad_di_i(pad_di_i), .core_di_o(core_di_o),
    .core_do_i(core_do_i), .core_oe_i(core_oe_i),
    .pad_do_o(pad_do_o), .pad_oe_o(pad_oe_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LEN-1:0] obs_vec(input logic [NP-1:0] pdi, cdo, coe);
    logic [LEN-1:0] v;
    for (int p = 0; p < NP; p++) begin
      v[3*p] = pdi[p]; v[3*p+1] = cdo[p]; v[3*p+2] = coe[p];
    end
    return v;
  endfunction

  function automatic logic [3*NP-1:0] drv_of(input logic [LEN-1:0] pat);
    logic [NP-1:0] di, dout, oe;
    for (int p = 0; p < NP; p++) begin
      di[p] = pat[3*p]; dout[p] = pat[3*p+1]; oe[p] = pat[3*p+2];
    end
    return {di, dout, oe};
  endfunction

  task automatic pulse_capture();
    @(negedge tck); capture_i = 1;
    @(posedge tck); #0.5 capture_i = 0;
  endtask

  task automatic pulse_update();
    @(negedge tck); update_i = 1;
    @(posedge tck); #0.5 update_i = 0;
  endtask

  task automatic scan(input logic [LEN-1:0] pat, output logic [LEN-1:0] got);
    for (int k = 0; k < LEN; k++) begin
      @(negedge tck);
      got[LEN-1-k] = tdo_o;
      tdi_i = pat[LEN-1-k];
      shift_i = 1;
    end
    @(negedge tck); shift_i = 0;
  endtask

  function automatic logic [3*NP-1:0] outs();
    return {core_di_o, pad_do_o, pad_oe_o};
  endfunction

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [LEN-1:0] got, pat;
    logic [1:0] m;
    // R1: reset state
    pad_di_i = 4'h5; core_do_i = 4'hA; core_oe_i = 4'hC;
    #12;
    chk("R1 tdo in reset", {31'd0, tdo_o}, 32'd0);
    chk("R1/R2 functional in reset", outs(), {4'h5, 4'hA, 4'hC});
    @(negedge tck); rst_ni = 1;
    mode_i = M_EXT;
    scan('0, got);
    chk("R1 chain cleared", got, '0);
    chk("R2 functional before update", outs(), {4'h5, 4'hA, 4'hC});

    foreach (TBL[e]) begin
      m = TBL[e][25:24]; pat = TBL[e][23:12];
      pad_di_i = TBL[e][11:8]; core_do_i = TBL[e][7:4]; core_oe_i = TBL[e][3:0];
      mode_i = m;
      pulse_capture();
      scan(pat, got);
      chk("R4/R5 captured vector", got, obs_vec(pad_di_i, core_do_i, core_oe_i));
      pulse_update();
      @(negedge tck);
      if (m == M_EXT) chk("R3 extest drive", outs(), drv_of(pat));
      else chk("R7 sample keeps functional", outs(), {pad_di_i, core_do_i, core_oe_i});
    end

    // R6: shifting while EXTEST drives (hold = 924)
    scan(12'hFFF, got);
    chk("R6 stable during shift", outs(), drv_of(12'h924));
    chk("R6 scanned out previous pattern", got, 12'h924);
    pulse_update();
    @(negedge tck);
    chk("R3 new pattern driven", outs(), drv_of(12'hFFF));

    // R9: strobes in functional / reserved mode ignored
    pad_di_i = 4'h0; core_do_i = 4'h0; core_oe_i = 4'h0;
    mode_i = M_FUNC;
    pulse_capture();
    scan(12'h000, got);
    mode_i = 2'd3;
    pulse_capture();
    mode_i = M_SAMP;
    scan(12'h3C3, got);
    chk("R9 chain untouched by idle strobes", got, 12'hFFF);

    // R8: update outside EXTEST releases pads
    chk("R6 still driving before release", outs(), drv_of(12'hFFF));
    mode_i = M_FUNC;
    pulse_update();
    @(negedge tck);
    chk("R8 update in functional releases", outs(), 12'h000);

    // R5: capture wins over simultaneous shift
    pad_di_i = 4'h9; core_do_i = 4'h4; core_oe_i = 4'h2;
    mode_i = M_SAMP;
    @(negedge tck); capture_i = 1; shift_i = 1; tdi_i = 1;
    @(posedge tck); #0.5 capture_i = 0; shift_i = 0;
    scan('0, got);
    chk("R5 capture priority", got, obs_vec(4'h9, 4'h4, 4'h2));

    // R8: reset leaves EXTEST
    mode_i = M_EXT;
    scan(12'hB6D, got);
    pulse_update();
    @(negedge tck);
    chk("R3 driven before reset", outs(), drv_of(12'hB6D));
    rst_ni = 0;
    #1;
    chk("R8 reset releases", outs(), {4'h9, 4'h4, 4'h2});
    chk("R1 tdo after reset", {31'd0, tdo_o}, 32'd0);
    @(negedge tck); rst_ni = 1;
    @(negedge tck);
    chk("R1 functional after release", outs(), {4'h9, 4'h4, 4'h2});

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule